// File: doc/BRIEF.md
# Memory-Management Abort Status Registers

This block holds the three status words that a trap handler reads after a memory-management abort, so that it can repair the cause and restart the failed instruction. The control word carries the abort cause flags, the number of the faulting page, the processor mode of the access, an instruction-complete flag and the mapping enable bit. The change log records up to two register auto-increments or auto-decrements made by the current instruction. The address word holds the virtual address of the instruction or vector that was being processed.

The instruction sequencer sends events into the block: instruction start and vector flow start, each with an address; register updates with a register number and a signed amount; and aborts with a cause, a page and a mode. An abort freezes all three words until software clears the cause flags with a bus write. Address translation and the page descriptor tables live elsewhere.

Top module: `mmu_abort_stat`

## Requirements
- R1: After reset, `statReg`, `chgLog` and `faultVa` are all zero and `frozen` is 0.
- R2: A bus write loads `busData[15:13]` into the cause flags and `busData[0]` into the enable bit. It leaves the page, mode and instruction-complete fields unchanged. `frozen` is 1 exactly when any cause flag is set.
- R3: While unfrozen, an instruction start loads `faultVa` with `instAddr` and clears `chgLog`. A vector start does the same with `vecAddr`. Both take effect one cycle after the event.
- R4: While unfrozen, the first register update since the last start is written to `chgLog[7:0]` and the second to `chgLog[15:8]`. Each byte is {amount[4:0] two's complement, register number[2:0]}, so two updates of register 6 by -2 give 16'hF6F6 and one update of register 1 by +2 gives 16'h0011. A third update is ignored.
- R5: An unfrozen abort sets the cause flags from `abortCause`: bit 2 goes to stat[15] (not resident), bit 1 to stat[14] (length), bit 0 to stat[13] (read only). The page goes to stat[3:1] and the mode to stat[6:5]. The block is frozen from the next cycle.
- R6: An abort during a vector flow (since a vector start, or in the same cycle as one) sets stat[12], and `faultVa` then holds the vector address.
- R7: An abort during the first instruction after a vector flow, including one in the same cycle as that instruction's start, leaves stat[12] at 0, and `faultVa` holds that instruction's address.
- R8: While frozen, starts, register updates and further aborts leave `statReg`, `chgLog` and `faultVa` unchanged.
- R9: A bus write that clears all cause flags unfreezes the block, and later sequencer events update the words again.
- R10: An instruction that aborts before updating any register leaves `chgLog` at zero.
- R11: Every register update amount lies in the 5-bit signed range -16 to +15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| instStart | input | 1 | Sequencer begins an instruction |
| instAddr | input | 16 | Virtual address of that instruction |
| vecStart | input | 1 | Sequencer begins a vector flow |
| vecAddr | input | 16 | Vector address of that flow |
| regUpd | input | 1 | Auto-increment/decrement of a general register |
| regNum | input | 3 | Register number of the update |
| regAmt | input | 8 | Signed update amount |
| abortEv | input | 1 | Memory-management abort of the current access |
| abortCause | input | 3 | Cause: [2] not resident, [1] length, [0] read only |
| abortPage | input | 3 | Page number of the faulting access |
| abortMode | input | 2 | Processor mode of the faulting access |
| busWr | input | 1 | Bus write to the control word |
| busData | input | 16 | Bus write data |
| statReg | output | 16 | Control word |
| chgLog | output | 16 | Register change log |
| faultVa | output | 16 | Instruction or vector address |
| frozen | output | 1 | Any cause flag set; words locked |

## Verification
The bench targets the ordering corners of the instruction-complete flag. One case is an abort that arrives in the same cycle as the start of a handler's first instruction: a design that samples its vector-flow state one cycle late would set stat[12] and keep the vector address. Another is an abort in the same cycle as a vector start, which must set the flag and capture the vector. The bench also sends updates and aborts while the block is frozen, and a third log update: a design without a working lock or a working log count would overwrite the evidence the handler needs. Finally it checks that a bus write preserves the page and mode fields while it clears the causes.

// File: rtl/mmu_abort_pkg.sv
package mmu_abort_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrLog;     // start of instruction or vector: empty change log
    logic wrLow;      // write first log entry
    logic wrHigh;     // write second log entry
    logic loadVa;     // latch start address
    logic vaFromVec;  // address source is the vector address
    logic capture;    // record abort into control word
    logic icoVal;     // instruction-complete value to record
    logic wrBus;      // bus write to control word
  } ctlStrobe_t;

  // control word bit positions (decoded by software handlers)
  localparam int unsigned CAUSE_HI = 15;
  localparam int unsigned CAUSE_LO = 13;
  localparam int unsigned ICO_BIT  = 12;
  localparam int unsigned MODE_LO  = 5;
  localparam int unsigned PAGE_LO  = 1;
  localparam int unsigned EN_BIT   = 0;

endpackage

// File: rtl/mmu_abort_ctl.sv
module mmu_abort_ctl
  import mmu_abort_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instStart,
  input  logic       vecStart,
  input  logic       regUpd,
  input  logic       abortEv,
  input  logic       busWr,
  input  logic       frozen,
  output ctlStrobe_t stb
);

  logic       inVec;
  logic [1:0] logCnt;
  logic       live;
  logic       newStart;
  logic       nextInVec;
  logic [1:0] effCnt;

  always_comb begin
    live      = !frozen;
    newStart  = live && (instStart || vecStart);
    nextInVec = inVec;
    if (live && vecStart)       nextInVec = 1'b1;
    else if (live && instStart) nextInVec = 1'b0;
    effCnt    = newStart ? 2'd0 : logCnt;

    stb           = '0;
    stb.clrLog    = newStart;
    stb.loadVa    = newStart;
    stb.vaFromVec = vecStart;
    stb.wrLow     = live && regUpd && (effCnt == 2'd0);
    stb.wrHigh    = live && regUpd && (effCnt == 2'd1);
    stb.capture   = live && abortEv;
    stb.icoVal    = nextInVec;
    stb.wrBus     = busWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inVec  <= 1'b0;
      logCnt <= 2'd0;
    end else begin
      inVec <= nextInVec;
      if (stb.wrLow)       logCnt <= 2'd1;
      else if (stb.wrHigh) logCnt <= 2'd2;
      else if (newStart)   logCnt <= 2'd0;
    end
  end

endmodule

// File: rtl/mmu_abort_dp.sv
module mmu_abort_dp
  import mmu_abort_pkg::*;
#(
  parameter int unsigned VA_W     = 16,
  parameter int unsigned NUM_W    = 3,
  parameter int unsigned AMT_W    = 5,
  parameter int unsigned IN_AMT_W = 8,
  parameter int unsigned PAGE_W   = 3,
  parameter int unsigned MODE_W   = 2,
  localparam int unsigned ENT_W   = NUM_W + AMT_W,
  localparam int unsigned LOG_W   = 2 * ENT_W,
  localparam int unsigned CAUSE_W = CAUSE_HI - CAUSE_LO + 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          stb,
  input  logic [VA_W-1:0]     instAddr,
  input  logic [VA_W-1:0]     vecAddr,
  input  logic [NUM_W-1:0]    regNum,
  input  logic [IN_AMT_W-1:0] regAmt,
  input  logic [CAUSE_W-1:0]  abortCause,
  input  logic [PAGE_W-1:0]   abortPage,
  input  logic [MODE_W-1:0]   abortMode,
  input  logic [15:0]         busData,
  output logic [15:0]         statReg,
  output logic [LOG_W-1:0]    chgLog,
  output logic [VA_W-1:0]     faultVa,
  output logic                frozen
);

  logic [CAUSE_W-1:0] causeQ;
  logic               icoQ;
  logic [MODE_W-1:0]  modeQ;
  logic [PAGE_W-1:0]  pageQ;
  logic               enQ;
  logic [ENT_W-1:0]   entry;

  assign entry = {regAmt[AMT_W-1:0], regNum};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ  <= '0;
      icoQ    <= 1'b0;
      modeQ   <= '0;
      pageQ   <= '0;
      enQ     <= 1'b0;
      chgLog  <= '0;
      faultVa <= '0;
    end else begin
      if (stb.wrBus) begin
        causeQ <= busData[CAUSE_HI:CAUSE_LO];
        enQ    <= busData[EN_BIT];
      end
      if (stb.capture) begin
        causeQ <= abortCause;
        pageQ  <= abortPage;
        modeQ  <= abortMode;
        icoQ   <= stb.icoVal;
      end
      if (stb.clrLog) chgLog <= '0;
      if (stb.wrLow)  chgLog[ENT_W-1:0] <= entry;
      if (stb.wrHigh) chgLog[LOG_W-1:ENT_W] <= entry;
      if (stb.loadVa) faultVa <= stb.vaFromVec ? vecAddr : instAddr;
    end
  end

  always_comb begin
    statReg = '0;
    statReg[CAUSE_HI:CAUSE_LO]        = causeQ;
    statReg[ICO_BIT]                  = icoQ;
    statReg[MODE_LO +: MODE_W]        = modeQ;
    statReg[PAGE_LO +: PAGE_W]        = pageQ;
    statReg[EN_BIT]                   = enQ;
  end

  assign frozen = |causeQ;

endmodule

// File: rtl/mmu_abort_stat.sv
module mmu_abort_stat
  import mmu_abort_pkg::*;
#(
  parameter int unsigned VA_W     = 16,
  parameter int unsigned NUM_W    = 3,
  parameter int unsigned AMT_W    = 5,
  parameter int unsigned IN_AMT_W = 8,
  parameter int unsigned PAGE_W   = 3,
  parameter int unsigned MODE_W   = 2
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      instStart,
  input  logic [VA_W-1:0]           instAddr,
  input  logic                      vecStart,
  input  logic [VA_W-1:0]           vecAddr,
  input  logic                      regUpd,
  input  logic [NUM_W-1:0]          regNum,
  input  logic [IN_AMT_W-1:0]       regAmt,
  input  logic                      abortEv,
  input  logic [2:0]                abortCause,
  input  logic [PAGE_W-1:0]         abortPage,
  input  logic [MODE_W-1:0]         abortMode,
  input  logic                      busWr,
  input  logic [15:0]               busData,
  output logic [15:0]               statReg,
  output logic [2*(NUM_W+AMT_W)-1:0] chgLog,
  output logic [VA_W-1:0]           faultVa,
  output logic                      frozen
);

  ctlStrobe_t stb;

  mmu_abort_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .instStart (instStart),
    .vecStart  (vecStart),
    .regUpd    (regUpd),
    .abortEv   (abortEv),
    .busWr     (busWr),
    .frozen    (frozen),
    .stb       (stb)
  );

  mmu_abort_dp #(
    .VA_W     (VA_W),
    .NUM_W    (NUM_W),
    .AMT_W    (AMT_W),
    .IN_AMT_W (IN_AMT_W),
    .PAGE_W   (PAGE_W),
    .MODE_W   (MODE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .instAddr   (instAddr),
    .vecAddr    (vecAddr),
    .regNum     (regNum),
    .regAmt     (regAmt),
    .abortCause (abortCause),
    .abortPage  (abortPage),
    .abortMode  (abortMode),
    .busData    (busData),
    .statReg    (statReg),
    .chgLog     (chgLog),
    .faultVa    (faultVa),
    .frozen     (frozen)
  );

endmodule

// File: rtl/mmu_abort_stat_chk.sv
module mmu_abort_stat_chk #(
  parameter int unsigned VA_W     = 16,
  parameter int unsigned AMT_W    = 5,
  parameter int unsigned IN_AMT_W = 8,
  parameter int unsigned LOG_W    = 16
)(
  input logic                clk,
  input logic                rstN,
  input logic                instStart,
  input logic                vecStart,
  input logic [VA_W-1:0]     instAddr,
  input logic                regUpd,
  input logic [IN_AMT_W-1:0] regAmt,
  input logic                abortEv,
  input logic                busWr,
  input logic [15:0]         statReg,
  input logic [LOG_W-1:0]    chgLog,
  input logic [VA_W-1:0]     faultVa,
  input logic                frozen
);

  // R3
  inst_addr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && instStart && !vecStart) |=> (faultVa == $past(instAddr)));

  // R5
  abort_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && abortEv && !busWr) |=> frozen);

  // R6
  vec_abort_ico_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && abortEv && vecStart) |=> statReg[12]);

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    frozen |=> ($stable(faultVa) && $stable(chgLog)));

  // R8
  frozen_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !busWr) |=> $stable(statReg));

  // R11
  amt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    regUpd |-> ((regAmt[IN_AMT_W-1:AMT_W-1] == '0) ||
                (regAmt[IN_AMT_W-1:AMT_W-1] == '1)));

endmodule

bind mmu_abort_stat mmu_abort_stat_chk #(
  .VA_W     (VA_W),
  .AMT_W    (AMT_W),
  .IN_AMT_W (IN_AMT_W),
  .LOG_W    (2*(NUM_W+AMT_W))
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instStart (instStart),
  .vecStart  (vecStart),
  .instAddr  (instAddr),
  .regUpd    (regUpd),
  .regAmt    (regAmt),
  .abortEv   (abortEv),
  .busWr     (busWr),
  .statReg   (statReg),
  .chgLog    (chgLog),
  .faultVa   (faultVa),
  .frozen    (frozen)
);

// File: tb/mmu_abort_stat_tb.sv
module mmu_abort_stat_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instStart = 1'b0, vecStart = 1'b0, regUpd = 1'b0;
  logic        abortEv = 1'b0, busWr = 1'b0;
  logic [15:0] instAddr = '0, vecAddr = '0, busData = '0;
  logic [2:0]  regNum = '0, abortCause = '0, abortPage = '0;
  logic [7:0]  regAmt = '0;
  logic [1:0]  abortMode = '0;
  logic [15:0] statReg, chgLog, faultVa;
  logic        frozen;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mmu_abort_stat u_dut (
    .clk(clk), .rstN(rstN),
    .instStart(instStart), .instAddr(instAddr),
    .vecStart(vecStart), .vecAddr(vecAddr),
    .regUpd(regUpd), .regNum(regNum), .regAmt(regAmt),
    .abortEv(abortEv), .abortCause(abortCause),
    .abortPage(abortPage), .abortMode(abortMode),
    .busWr(busWr), .busData(busData),
    .statReg(statReg), .chgLog(chgLog), .faultVa(faultVa), .frozen(frozen)
  );

  typedef struct packed {
    logic        ist, vst, upd, abt, wr;
    logic [15:0] addr;
    logic [2:0]  num;
    logic [7:0]  amt;
    logic [2:0]  cause;
    logic [2:0]  page;
    logic [1:0]  mode;
    logic [15:0] wdata;
    logic [15:0] eStat, eLog, eVa;
    logic        eFr;
    logic [23:0] tag;
  } row_t;

  localparam int NROWS = 17;
  localparam row_t TBL [NROWS] = '{
    '{0,0,0,0,1, 16'h0000, 3'd0, 8'h00, 3'b000, 3'd0, 2'd0, 16'h0001, 16'h0001, 16'h0000, 16'h0000, 1'b0, "R2 "},
    '{1,0,0,0,0, 16'h1000, 3'd0, 8'h00, 3'b000, 3'd0, 2'd0, 16'h0000, 16'h0001, 16'h0000, 16'h1000, 1'b0, "R3 "},
    '{0,0,1,0,0, 16'h0000, 3'd1, 8'h02, 3'b000, 3'd0, 2'd0, 16'h0000, 16'h0001, 16'h0011, 16'h1000, 1'b0, "R4 "},
    '{0,0,0,1,0, 16'h0000, 3'd0, 8'h00, 3'b100, 3'd6, 2'd0, 16'h0000, 16'h800D, 16'h0011, 16'h1000, 1'b1, "R5 "},
    '{1,0,0,0,0, 16'h2000, 3'd0, 8'h00, 3'b000, 3'd0, 2'd0, 16'h0000, 16'h800D, 16'h0011, 16'h1000, 1'b1, "R8 "},
    '{0,0,1,0,0, 16'h0000, 3'd6, 8'hFE, 3'b000, 3'd0, 2'd0, 16'h0000, 16'h800D, 16'h0011, 16'h1000, 1'b1, "R8 "},
    '{0,0,0,0,1, 16'h0000, 3'd0, 8'h00, 3'b000, 3'd0, 2'd0, 16'h0001, 16'h000D, 16'h0011, 16'h1000, 1'b0, "R9 "},
    '{0,1,0,0,0, 16'h00A0, 3'd0, 8'h00, 3'b000, 3'd0, 2'd0, 16'h0000, 16'h000D, 16'h0000, 16'h00A0, 1'b0, "R3 "},
    '{0,0,1,0,0, 16'h0000, 3'd6, 8'hFE, 3'b000, 3'd0, 2'd0, 16'h0000, 16'h000D, 16'h00F6, 16'h00A0, 1'b0, "R4 "},
    '{0,0,1,0,0, 16'h0000, 3'd6, 8'hFE, 3'b000, 3'd0, 2'd0, 16'h0000, 16'h000D, 16'hF6F6, 16'h00A0, 1'b0, "R4 "},
    '{0,0,1,0,0, 16'h0000, 3'd2, 8'h01, 3'b000, 3'd0, 2'd0, 16'h0000, 16'h000D, 16'hF6F6, 16'h00A0, 1'b0, "R4 "},
    '{0,0,0,1,0, 16'h0000, 3'd0, 8'h00, 3'b100, 3'd5, 2'd1, 16'h0000, 16'h902B, 16'hF6F6, 16'h00A0, 1'b1, "R6 "},
    '{0,0,0,0,1, 16'h0000, 3'd0, 8'h00, 3'b000, 3'd0, 2'd0, 16'h0001, 16'h102B, 16'hF6F6, 16'h00A0, 1'b0, "R2 "},
    '{1,0,0,0,0, 16'h3000, 3'd0, 8'h00, 3'b000, 3'd0, 2'd0, 16'h0000, 16'h102B, 16'h0000, 16'h3000, 1'b0, "R9 "},
    '{0,0,0,1,0, 16'h0000, 3'd0, 8'h00, 3'b010, 3'd2, 2'd3, 16'h0000, 16'h4065, 16'h0000, 16'h3000, 1'b1, "R10"},
    '{0,0,0,1,0, 16'h0000, 3'd0, 8'h00, 3'b001, 3'd7, 2'd0, 16'h0000, 16'h4065, 16'h0000, 16'h3000, 1'b1, "R8 "},
    '{0,0,0,0,1, 16'h0000, 3'd0, 8'h00, 3'b000, 3'd0, 2'd0, 16'h0000, 16'h0064, 16'h0000, 16'h3000, 1'b0, "R2 "}
  };

  task automatic clearIn();
    instStart = 0; vecStart = 0; regUpd = 0; abortEv = 0; busWr = 0;
  endtask

  task automatic expect4(input [15:0] eS, input [15:0] eL, input [15:0] eV,
                         input logic eF, input string tag);
    total++;
    if (statReg !== eS || chgLog !== eL || faultVa !== eV || frozen !== eF) begin
      bad++;
      $display("FAIL %s: stat=%h log=%h va=%h fr=%b expected stat=%h log=%h va=%h fr=%b",
               tag, statReg, chgLog, faultVa, frozen, eS, eL, eV, eF);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    clearIn();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1: reset state
    expect4(16'h0000, 16'h0000, 16'h0000, 1'b0, "R1");

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      instStart = TBL[i].ist; vecStart = TBL[i].vst; regUpd = TBL[i].upd;
      abortEv = TBL[i].abt; busWr = TBL[i].wr;
      instAddr = TBL[i].addr; vecAddr = TBL[i].addr;
      regNum = TBL[i].num; regAmt = TBL[i].amt;
      abortCause = TBL[i].cause; abortPage = TBL[i].page; abortMode = TBL[i].mode;
      busData = TBL[i].wdata;
      tick();
      expect4(TBL[i].eStat, TBL[i].eLog, TBL[i].eVa, TBL[i].eFr, string'(TBL[i].tag));
    end

    // R7: vector flow, then abort in same cycle as handler's first instruction start
    @(negedge clk); vecStart = 1; vecAddr = 16'h0090; tick();
    expect4(16'h0064, 16'h0000, 16'h0090, 1'b0, "R3");
    @(negedge clk);
    instStart = 1; instAddr = 16'h5000;
    abortEv = 1; abortCause = 3'b100; abortPage = 3'd6; abortMode = 2'd0;
    tick();
    expect4(16'h800C, 16'h0000, 16'h5000, 1'b1, "R7");

    // R6: abort in the same cycle as a vector start
    @(negedge clk); busWr = 1; busData = 16'h0000; tick();
    expect4(16'h000C, 16'h0000, 16'h5000, 1'b0, "R9");
    @(negedge clk);
    vecStart = 1; vecAddr = 16'h0084;
    abortEv = 1; abortCause = 3'b001; abortPage = 3'd3; abortMode = 2'd0;
    tick();
    expect4(16'h3006, 16'h0000, 16'h0084, 1'b1, "R6");

    // R1: reset in mid-run clears everything
    @(negedge clk); rstN = 1'b0; tick();
    @(negedge clk); rstN = 1'b1; #1;
    expect4(16'h0000, 16'h0000, 16'h0000, 1'b0, "R1");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule